// File: doc/BRIEF.md
# Banked Programmable Clock Divider Set

This block takes one fast source clock and produces three banks of divided clocks plus a single feedback clock. Each bank has four outputs that carry the same clock. The divide ratio of a bank is set by its own 2-bit select. The feedback output is set by a 3-bit select. One range bit is shared by all of them and doubles every ratio when it is low. Every ratio is even, so each output toggles once every half-ratio source cycles and has a 50% duty cycle.

The selects, the range bit and the invert control are captured on each source edge while the active-low reset/output-enable input is low. They are held for as long as the block runs. While that input is low, every output is released to high impedance and every divider is held. On release, all dividers start in the same source cycle and rise on the first source edge. Their rising edges therefore coincide again at every common multiple of the chosen ratios. The upper pair of bank C outputs can be set to run inverted against the lower pair.

Top module: `clk_bank_divider`

## Requirements
- R1: With range_hi = 1, bank A divides the source by 4, 6, 8 and 12 for sel_a = 00, 01, 10 and 11.
- R2: With range_hi = 1, bank B divides the source by 4, 6, 8 and 10 for sel_b = 00, 01, 10 and 11.
- R3: With range_hi = 1, bank C divides the source by 2, 4, 6 and 8 for sel_c = 00, 01, 10 and 11.
- R4: With range_hi = 0, every bank ratio is twice its range_hi = 1 value: bank A 8/12/16/24, bank B 8/12/16/20, bank C 4/8/12/16 for codes 00 to 11.
- R5: For sel_fb = 000 to 111, the feedback output divides by 4, 6, 8, 10, 8, 12, 16, 20 when range_hi = 1, and by 8, 12, 16, 20, 16, 24, 32, 40 when range_hi = 0.
- R6: Every output with ratio R is high for exactly R/2 source cycles and low for R/2 source cycles.
- R7: All four outputs of bank A are equal, all four outputs of bank B are equal, qc[0] equals qc[1], and qc[2] equals qc[3].
- R8: With inv_hi = 1, qc[2] and qc[3] are the complement of qc[0]. With inv_hi = 0, they equal qc[0].
- R9: While rst_oe_n = 0, no output drives a high level (outputs are high impedance) and all dividers are held.
- R10: On the first source rising edge with rst_oe_n = 1, every non-inverted output rises.
- R11: After release, all non-inverted outputs are low in source cycle L and rise together in cycle L+1, where L is the least common multiple of the four active ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock that all dividers count |
| rst_oe_n | input | 1 | Active-low reset and output enable. Low holds the block and floats the outputs |
| range_hi | input | 1 | Range bit. 0 doubles every ratio |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_hi | input | 1 | 1 inverts the upper pair of bank C |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks. Bits 3:2 can be inverted |
| qfb | output | 1 | Feedback clock |

## Verification
Directed configurations visit every select code of every bank and of the feedback divider in both ranges. A ratio wrongly mapped to its code then shows up as a cycle-by-cycle waveform mismatch that names the bank involved. Configurations drawn from a seeded random source mix ratios whose common multiple is large, for example 24 against 20 against 40. These show whether all dividers truly restart in the same cycle, because a one-cycle offset in any divider breaks the joint rise at the common multiple. Both settings of the invert bit are applied with each kind of configuration. This separates a fault in the bank C inversion from a fault in fan-out equality.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

   localparam int unsigned MAX_HALF   = 20;
   localparam int unsigned MIN_CNT_W  = $clog2(MAX_HALF + 1);

   // half-ratios at range_hi = 1; doubled when the range bit is low
   function automatic int unsigned scale_half(input logic rng, input int unsigned base);
      return rng ? base : 2 * base;
   endfunction

   function automatic int unsigned half_bank_a(input logic rng, input logic [1:0] s);
      int unsigned b;
      case (s)
         2'd0:    b = 2;
         2'd1:    b = 3;
         2'd2:    b = 4;
         default: b = 6;
      endcase
      return scale_half(rng, b);
   endfunction

   function automatic int unsigned half_bank_b(input logic rng, input logic [1:0] s);
      return scale_half(rng, int'(s) + 2);
   endfunction

   function automatic int unsigned half_bank_c(input logic rng, input logic [1:0] s);
      return scale_half(rng, int'(s) + 1);
   endfunction

   function automatic int unsigned half_feedback(input logic rng, input logic [2:0] s);
      int unsigned b;
      b = int'(s[1:0]) + 2;
      if (s[2]) b = 2 * b;
      return scale_half(rng, b);
   endfunction

endpackage

// File: rtl/clkdiv_cfg_capture.sv
`timescale 1ns/1ps
module clkdiv_cfg_capture
   import clkdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rng,
   input  logic [1:0]       sel_a,
   input  logic [1:0]       sel_b,
   input  logic [1:0]       sel_c,
   input  logic [2:0]       sel_fb,
   input  logic             inv,
   output logic [CNT_W-1:0] half_a,
   output logic [CNT_W-1:0] half_b,
   output logic [CNT_W-1:0] half_c,
   output logic [CNT_W-1:0] half_fb,
   output logic             inv_q
);

   logic rng_q;

   // settings follow the inputs only while held in reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rng_q   <= rng;
         inv_q   <= inv;
         half_a  <= CNT_W'(half_bank_a(rng, sel_a));
         half_b  <= CNT_W'(half_bank_b(rng, sel_b));
         half_c  <= CNT_W'(half_bank_c(rng, sel_c));
         half_fb <= CNT_W'(half_feedback(rng, sel_fb));
      end
   end

   // low range doubles ratios that are all multiples of 4, so halves are even
   assert_double_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rng_q |-> (!half_a[0] && !half_b[0] && !half_c[0] && !half_fb[0]));

   // feedback half-ratio stays in its range window
   assert_fb_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rng_q |-> (half_fb >= CNT_W'(2) && half_fb <= CNT_W'(10)));

endmodule

// File: rtl/clkdiv_toggle.sv
`timescale 1ns/1ps
module clkdiv_toggle #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] half,
   output logic             q
);

   logic [CNT_W-1:0] cnt;

   // counter starts at zero so the first active edge flips the output high
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (cnt == '0) begin
         cnt <= half - CNT_W'(1);
         q   <= ~q;
      end else begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   // independent level-length monitor
   logic             q_d;
   logic             seen;
   logic [CNT_W-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_d     <= 1'b0;
         seen    <= 1'b0;
         run_len <= '0;
      end else begin
         q_d <= q;
         if (q != q_d) begin
            seen    <= 1'b1;
            run_len <= CNT_W'(1);
         end else begin
            run_len <= run_len + CNT_W'(1);
         end
      end
   end

   assert_level_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && (q != q_d)) |-> (run_len == half));

   assert_first_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |=> q);

endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank #(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned N_OUT = 4,
   parameter int unsigned N_INV = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] half,
   input  logic             inv,
   output logic [N_OUT-1:0] lvl
);

   localparam int unsigned FIRST_INV = N_OUT - N_INV;

   logic q;

   clkdiv_toggle #(.CNT_W(CNT_W)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .half  (half),
      .q     (q)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_fan
      if (i >= FIRST_INV) begin : g_inv
         assign lvl[i] = q ^ inv;
      end else begin : g_plain
         assign lvl[i] = q;
      end
   end

   if (N_INV > 0 && N_INV < N_OUT) begin : g_inv_chk
      assert_inv_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl[N_OUT-1] != lvl[0]) == inv);
   end

endmodule

// File: rtl/clk_bank_divider.sv
`timescale 1ns/1ps
module clk_bank_divider
   import clkdiv_pkg::*;
#(
   parameter int unsigned OUTS_PER_BANK = 4,
   parameter int unsigned INV_OUTS      = 2,
   parameter int unsigned CNT_W         = 6
) (
   input  logic                     src_clk,
   input  logic                     rst_oe_n,
   input  logic                     range_hi,
   input  logic [1:0]               sel_a,
   input  logic [1:0]               sel_b,
   input  logic [1:0]               sel_c,
   input  logic [2:0]               sel_fb,
   input  logic                     inv_hi,
   output logic [OUTS_PER_BANK-1:0] qa,
   output logic [OUTS_PER_BANK-1:0] qb,
   output logic [OUTS_PER_BANK-1:0] qc,
   output logic                     qfb
);

   initial begin
      assert (CNT_W >= MIN_CNT_W) else $error("CNT_W too small for largest half-ratio");
      assert (OUTS_PER_BANK >= 1) else $error("OUTS_PER_BANK must be at least 1");
      assert (INV_OUTS <= OUTS_PER_BANK) else $error("INV_OUTS exceeds bank size");
   end

   logic [CNT_W-1:0]         half_a, half_b, half_c, half_fb;
   logic                     inv_q;
   logic [OUTS_PER_BANK-1:0] lvl_a, lvl_b, lvl_c;
   logic [0:0]               lvl_fb;

   clkdiv_cfg_capture #(.CNT_W(CNT_W)) cfg_i (
      .clk     (src_clk),
      .rst_n   (rst_oe_n),
      .rng     (range_hi),
      .sel_a   (sel_a),
      .sel_b   (sel_b),
      .sel_c   (sel_c),
      .sel_fb  (sel_fb),
      .inv     (inv_hi),
      .half_a  (half_a),
      .half_b  (half_b),
      .half_c  (half_c),
      .half_fb (half_fb),
      .inv_q   (inv_q)
   );

   clkdiv_bank #(.CNT_W(CNT_W), .N_OUT(OUTS_PER_BANK), .N_INV(0)) bank_a_i (
      .clk (src_clk), .rst_n (rst_oe_n), .half (half_a), .inv (1'b0), .lvl (lvl_a)
   );

   clkdiv_bank #(.CNT_W(CNT_W), .N_OUT(OUTS_PER_BANK), .N_INV(0)) bank_b_i (
      .clk (src_clk), .rst_n (rst_oe_n), .half (half_b), .inv (1'b0), .lvl (lvl_b)
   );

   clkdiv_bank #(.CNT_W(CNT_W), .N_OUT(OUTS_PER_BANK), .N_INV(INV_OUTS)) bank_c_i (
      .clk (src_clk), .rst_n (rst_oe_n), .half (half_c), .inv (inv_q), .lvl (lvl_c)
   );

   clkdiv_bank #(.CNT_W(CNT_W), .N_OUT(1), .N_INV(0)) bank_fb_i (
      .clk (src_clk), .rst_n (rst_oe_n), .half (half_fb), .inv (1'b0), .lvl (lvl_fb)
   );

   // outputs float while held in reset
   assign qa  = rst_oe_n ? lvl_a     : {OUTS_PER_BANK{1'bz}};
   assign qb  = rst_oe_n ? lvl_b     : {OUTS_PER_BANK{1'bz}};
   assign qc  = rst_oe_n ? lvl_c     : {OUTS_PER_BANK{1'bz}};
   assign qfb = rst_oe_n ? lvl_fb[0] : 1'bz;

endmodule

// File: tb/clk_bank_divider_tb_top.sv
`timescale 1ns/1ps
module clk_bank_divider_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rng = 1'b1;
   logic [1:0] sa = '0, sb = '0, sc = '0;
   logic [2:0] sf = '0;
   logic       inv = 1'b0;
   logic [3:0] qa, qb, qc;
   logic       qfb;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   clk_bank_divider dut_i (
      .src_clk (clk), .rst_oe_n (rst_n), .range_hi (rng),
      .sel_a (sa), .sel_b (sb), .sel_c (sc), .sel_fb (sf), .inv_hi (inv),
      .qa (qa), .qb (qb), .qc (qc), .qfb (qfb)
   );

   function automatic int ratio_a(bit r, int s);
      int v;
      case (s) 0: v = 4; 1: v = 6; 2: v = 8; default: v = 12; endcase
      return r ? v : 2 * v;
   endfunction
   function automatic int ratio_b(bit r, int s);
      int v;
      case (s) 0: v = 4; 1: v = 6; 2: v = 8; default: v = 10; endcase
      return r ? v : 2 * v;
   endfunction
   function automatic int ratio_c(bit r, int s);
      int v;
      case (s) 0: v = 2; 1: v = 4; 2: v = 6; default: v = 8; endcase
      return r ? v : 2 * v;
   endfunction
   function automatic int ratio_fb(bit r, int s);
      int v;
      case (s)
         0: v = 4;  1: v = 6;  2: v = 8;  3: v = 10;
         4: v = 8;  5: v = 12; 6: v = 16; default: v = 20;
      endcase
      return r ? v : 2 * v;
   endfunction
   function automatic int gcd(int x, int y);
      int t;
      while (y != 0) begin t = x % y; x = y; y = t; end
      return x;
   endfunction
   function automatic int lcm(int x, int y);
      return (x / gcd(x, y)) * y;
   endfunction
   function automatic bit exp_lvl(int r, int n);
      return ((n - 1) % r) < (r / 2);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_cfg(bit r, int a, int b, int c, int f, bit iv);
      int ra, rb, rc, rf, l, total;
      int bad[4], bad_act[4], bad_exp[4], highs[4], ratios[4];
      bit fan_ok, inv_ok, first_ok, low_ok, rise_ok, rst_ok;
      string tags[4];
      ra = ratio_a(r, a); rb = ratio_b(r, b); rc = ratio_c(r, c); rf = ratio_fb(r, f);
      ratios = '{ra, rb, rc, rf};
      l = lcm(lcm(ra, rb), lcm(rc, rf));
      total = l + 1;
      tags[0] = r ? "R1" : "R4";
      tags[1] = r ? "R2" : "R4";
      tags[2] = r ? "R3" : "R4";
      tags[3] = "R5";
      @(negedge clk);
      rst_n = 1'b0;
      rng = r; sa = 2'(a); sb = 2'(b); sc = 2'(c); sf = 3'(f); inv = iv;
      repeat (3) @(negedge clk);
      // R9: nothing driven high while held
      rst_ok = 1'b1;
      for (int i = 0; i < 4; i++)
         if (qa[i] === 1'b1 || qb[i] === 1'b1 || qc[i] === 1'b1) rst_ok = 1'b0;
      if (qfb === 1'b1) rst_ok = 1'b0;
      chk(rst_ok, "R9 outputs during reset", int'(rst_ok), 1);
      for (int k = 0; k < 4; k++) begin bad[k] = 0; highs[k] = 0; end
      fan_ok = 1'b1; inv_ok = 1'b1; first_ok = 1'b0; low_ok = 1'b0; rise_ok = 1'b0;
      rst_n = 1'b1;
      for (int n = 1; n <= total; n++) begin
         bit obs[4];
         @(negedge clk);
         obs = '{qa[0], qb[0], qc[0], qfb};
         for (int k = 0; k < 4; k++) begin
            bit e;
            e = exp_lvl(ratios[k], n);
            if (obs[k] !== e && bad[k] == 0) begin
               bad[k] = n; bad_act[k] = int'(obs[k]); bad_exp[k] = int'(e);
            end
            if (n <= l && obs[k] === 1'b1) highs[k]++;
         end
         if (qa !== {4{qa[0]}} || qb !== {4{qb[0]}} || qc[1] !== qc[0] || qc[3] !== qc[2])
            fan_ok = 1'b0;
         if (qc[2] !== (qc[0] ^ iv)) inv_ok = 1'b0;
         if (n == 1) first_ok = (qa[0] === 1'b1) && (qb[0] === 1'b1) && (qc[0] === 1'b1) && (qfb === 1'b1);
         if (n == l) low_ok = (qa[0] === 1'b0) && (qb[0] === 1'b0) && (qc[0] === 1'b0) && (qfb === 1'b0);
         if (n == l + 1) rise_ok = (qa[0] === 1'b1) && (qb[0] === 1'b1) && (qc[0] === 1'b1) && (qfb === 1'b1);
      end
      for (int k = 0; k < 4; k++) begin
         if (bad[k] != 0)
            chk(1'b0, $sformatf("%s ratio %0d waveform at cycle %0d", tags[k], ratios[k], bad[k]),
                bad_act[k], bad_exp[k]);
         else
            chk(1'b1, tags[k], 0, 0);
         chk(highs[k] == l / 2, $sformatf("R6 high cycles of output %0d", k), highs[k], l / 2);
      end
      chk(fan_ok, "R7 fan-out equality", int'(fan_ok), 1);
      chk(inv_ok, $sformatf("R8 bank C inversion inv=%0d", iv), int'(inv_ok), 1);
      chk(first_ok, "R10 first edge high", int'(first_ok), 1);
      chk(low_ok && rise_ok, $sformatf("R11 joint rise at cycle %0d", l + 1),
          int'(low_ok && rise_ok), 1);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4513);
      repeat (4) @(negedge clk);
      // directed: every code of every bank in both ranges
      for (int r = 0; r < 2; r++)
         for (int s = 0; s < 4; s++)
            run_cfg(bit'(r), s, s, s, s, bit'(s[0]));
      for (int r = 0; r < 2; r++)
         for (int f = 4; f < 8; f++)
            run_cfg(bit'(r), 3 - (f - 4), f - 4, 3, f, bit'(r));
      // seeded random mixes
      for (int t = 0; t < 14; t++)
         run_cfg(bit'($urandom_range(1, 0)), int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                 int'($urandom_range(3, 0)), int'($urandom_range(7, 0)), bit'($urandom_range(1, 0)));
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule